// File: doc/BRIEF.md
# Uncore Event Counter Bank

This block counts events for a shared cache slice. Each cycle the cache logic presents several event lanes. Each lane carries a valid bit and an 8-bit event code. Eight 48-bit counters each watch for one programmed code. A counter advances when three things hold: the global run bit is set, the counter's own enable bit is set, and a valid lane carries its code.

Software reaches the bank through a plain register port: a byte address, a write pulse, 64 bits of write data, 8 byte strobes, and combinational read data. The 32-bit control registers sit in bits 31:0 of the data bus and use strobes 3:0. Counters are 64-bit registers. When a counter wraps, it latches an overflow status bit. A single level interrupt output reports every status bit that is not masked.

Top module: `evbank_top`

## Requirements
- R1: After reset every counter reads 0. The run register (0x0408), the enable register (0x1C00) and the status register (0x0808) read 0. The mask register (0x0800) reads 0xFF. Both selector registers read 0xFFFFFFFF. The interrupt output is low.
- R2: Counter n is read and written as 64 bits at byte offset 0x1E00 + 8·n, with byte strobes applied per byte. Bits 63:48 always read 0, and writes to them are ignored.
- R3: Selector register 0x1D00 holds the codes for counters 0–3, and 0x1D04 holds the codes for counters 4–7. Counter n's code is the 8-bit field at bit 8·(n mod 4). Byte strobes update single fields.
- R4: Code 0xFF never counts, even when a valid lane carries 0xFF.
- R5: A counter adds exactly one in a cycle where bit 17 of 0x0408 is 1, its bit n of 0x1C00 is 1, and at least one valid lane (lane i's code in ev_code[8i+7:8i]) carries its code. Several matching lanes in the same cycle still add only one.
- R6: While bit 17 of 0x0408 is 0, or while bit n of 0x1C00 is 0, counter n holds its value whatever events arrive.
- R7: When counter n steps from 2^48−1 to 0, bit n of the status register 0x0808 becomes 1.
- R8: Writing 1 to bit n of 0x080C clears status bit n. Writing 0 bits leaves status unchanged.
- R9: The interrupt output is high exactly when some status bit n is 1 and mask bit n (0x0800, 1 = masked) is 0.
- R10: A bus write to a counter in the same cycle as a matching event stores the written value and drops the increment.
- R11: Reads of unmapped offsets and of the clear register 0x080C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_vld | input | LANES | Valid bit per event lane |
| ev_code | input | LANES·8 | Event code per lane, lane i in bits 8i+7:8i |
| bus_addr | input | 16 | Byte address of the register access |
| bus_wr | input | 1 | Write pulse |
| bus_wdata | input | 64 | Write data |
| bus_wstrb | input | 8 | Byte write strobes |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The bench loads a counter with all ones and fires its event once. A design with a wrong wrap width or a lost overflow would then show a non-zero count or a clear status bit. It drives cycles where several lanes carry the same code, and cycles with code 0xFF on every lane. Counters that advance by the number of matching lanes, or that treat 0xFF as a real code, give visibly wrong totals.

Partial-strobe writes go to a counter and to a single selector field; a design that ignored the strobes would corrupt neighbouring bytes. Writes also target the reserved counter bits, which a design that stored them would show on readback. A counter write collides with a matching event in the same cycle; a design that let the increment win would read back one too many. The interrupt is checked against the mask both before and after unmasking. The clear register is written first with zero bits and then with a one bit.

// File: rtl/evbank_pkg.sv
package evbank_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 64;
    localparam int STRB_W = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFS_RUN  = 16'h0408;
    localparam logic [ADDR_W-1:0] OFS_MASK = 16'h0800;
    localparam logic [ADDR_W-1:0] OFS_STAT = 16'h0808;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 16'h080C;
    localparam logic [ADDR_W-1:0] OFS_CEN  = 16'h1C00;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 16'h1D00;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 16'h1E00;

    localparam int RUN_BIT = 17;
    localparam logic [7:0] CODE_NONE = 8'hFF;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } bus_wr_t;

    function automatic logic [DATA_W-1:0] merge64(input logic [DATA_W-1:0] old_v,
                                                  input logic [DATA_W-1:0] new_v,
                                                  input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] res;
        for (int b = 0; b < STRB_W; b++)
            res[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        return res;
    endfunction

    function automatic logic [31:0] merge32(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [3:0]  strb);
        logic [31:0] res;
        for (int b = 0; b < 4; b++)
            res[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        return res;
    endfunction

endpackage

// File: rtl/evbank_ctrl.sv
module evbank_ctrl
    import evbank_pkg::*;
#(
    parameter int NUM_CNT  = 8,
    parameter int SEL_REGS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_wr_t               wr,
    input  logic [NUM_CNT-1:0]    ovf,
    output logic                  run,
    output logic [NUM_CNT-1:0]    cnt_en,
    output logic [NUM_CNT-1:0]    mask,
    output logic [NUM_CNT-1:0]    status,
    output logic [SEL_REGS*32-1:0] sel_regs,
    output logic                  irq
);

    logic [NUM_CNT-1:0] clr_bits;
    logic [31:0]        clr_word;

    always_comb begin
        clr_word = merge32(32'h0, wr.data[31:0], wr.strb[3:0]);
        clr_bits = (wr.en && wr.addr == OFS_CLR) ? clr_word[NUM_CNT-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            cnt_en   <= '0;
            mask     <= '1;
            status   <= '0;
            sel_regs <= '1;
        end else begin
            if (wr.en && wr.addr == OFS_RUN && wr.strb[RUN_BIT/8])
                run <= wr.data[RUN_BIT];
            if (wr.en && wr.addr == OFS_CEN)
                cnt_en <= NUM_CNT'(merge32(32'(cnt_en), wr.data[31:0], wr.strb[3:0]));
            if (wr.en && wr.addr == OFS_MASK)
                mask <= NUM_CNT'(merge32(32'(mask), wr.data[31:0], wr.strb[3:0]));
            for (int r = 0; r < SEL_REGS; r++) begin
                if (wr.en && wr.addr == OFS_SEL + ADDR_W'(4*r))
                    sel_regs[32*r +: 32] <= merge32(sel_regs[32*r +: 32],
                                                    wr.data[31:0], wr.strb[3:0]);
            end
            // a wrap in the same cycle as a clear keeps the bit set
            status <= (status & ~clr_bits) | ovf;
        end
    end

    assign irq = |(status & ~mask);

endmodule

// File: rtl/evbank_counter.sv
module evbank_counter
    import evbank_pkg::*;
#(
    parameter int CNT_W  = 48,
    parameter int CODE_W = 8,
    parameter int LANES  = 4,
    parameter int INDEX  = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    en,
    input  logic [CODE_W-1:0]       sel,
    input  logic [LANES-1:0]        lane_vld,
    input  logic [LANES*CODE_W-1:0] lane_code,
    input  bus_wr_t                 wr,
    output logic [CNT_W-1:0]        value,
    output logic                    ovf
);

    localparam logic [ADDR_W-1:0] MY_OFS = OFS_CNT + ADDR_W'(8*INDEX);

    logic hit;
    logic wr_hit;
    logic step;
    logic [DATA_W-1:0] merged;

    always_comb begin
        hit = 1'b0;
        for (int l = 0; l < LANES; l++)
            if (lane_vld[l] && lane_code[CODE_W*l +: CODE_W] == sel)
                hit = 1'b1;
        if (sel == CODE_W'(CODE_NONE))
            hit = 1'b0;
    end

    assign wr_hit = wr.en && wr.addr == MY_OFS;
    assign step   = run && en && hit && !wr_hit;
    assign merged = merge64(DATA_W'(value), wr.data, wr.strb);
    assign ovf    = step && (value == '1);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (wr_hit)
            value <= merged[CNT_W-1:0];
        else if (step)
            value <= value + CNT_W'(1);
    end

endmodule

// File: rtl/evbank_top.sv
module evbank_top
    import evbank_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 48,
    parameter int CODE_W  = 8,
    parameter int LANES   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        ev_vld,
    input  logic [LANES*CODE_W-1:0] ev_code,
    input  logic [15:0]             bus_addr,
    input  logic                    bus_wr,
    input  logic [63:0]             bus_wdata,
    input  logic [7:0]              bus_wstrb,
    output logic [63:0]             bus_rdata,
    output logic                    irq
);

    localparam int SEL_PER_REG = 32 / CODE_W;
    localparam int SEL_REGS    = (NUM_CNT + SEL_PER_REG - 1) / SEL_PER_REG;

    bus_wr_t                  wr;
    logic                     run;
    logic [NUM_CNT-1:0]       cnt_en;
    logic [NUM_CNT-1:0]       mask;
    logic [NUM_CNT-1:0]       status;
    logic [NUM_CNT-1:0]       ovf;
    logic [SEL_REGS*32-1:0]   sel_regs;
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;

    assign wr = '{en: bus_wr, addr: bus_addr, data: bus_wdata, strb: bus_wstrb};

    evbank_ctrl #(.NUM_CNT(NUM_CNT), .SEL_REGS(SEL_REGS)) u_ctrl (
        .clk(clk), .rst(rst), .wr(wr), .ovf(ovf),
        .run(run), .cnt_en(cnt_en), .mask(mask), .status(status),
        .sel_regs(sel_regs), .irq(irq)
    );

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        evbank_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W), .LANES(LANES), .INDEX(n)) u_cnt (
            .clk(clk), .rst(rst), .run(run), .en(cnt_en[n]),
            .sel(sel_regs[CODE_W*n +: CODE_W]),
            .lane_vld(ev_vld), .lane_code(ev_code), .wr(wr),
            .value(cnt_flat[CNT_W*n +: CNT_W]), .ovf(ovf[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RUN:  bus_rdata[RUN_BIT]     = run;
            OFS_MASK: bus_rdata[NUM_CNT-1:0] = mask;
            OFS_STAT: bus_rdata[NUM_CNT-1:0] = status;
            OFS_CEN:  bus_rdata[NUM_CNT-1:0] = cnt_en;
            default:  ;
        endcase
        for (int r = 0; r < SEL_REGS; r++)
            if (bus_addr == OFS_SEL + 16'(4*r))
                bus_rdata[31:0] = sel_regs[32*r +: 32];
        for (int n = 0; n < NUM_CNT; n++)
            if (bus_addr == OFS_CNT + 16'(8*n))
                bus_rdata[CNT_W-1:0] = cnt_flat[CNT_W*n +: CNT_W];
    end

endmodule

// File: rtl/evbank_chk.sv
module evbank_chk #(
    parameter int NUM_CNT  = 8,
    parameter int CNT_W    = 48,
    parameter int CODE_W   = 8,
    parameter int SEL_REGS = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     run,
    input logic [NUM_CNT-1:0]       cnt_en,
    input logic [NUM_CNT-1:0]       mask,
    input logic [NUM_CNT-1:0]       status,
    input logic [NUM_CNT-1:0]       ovf,
    input logic [SEL_REGS*32-1:0]   sel_regs,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat,
    input logic                     bus_wr,
    input logic                     irq
);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (mask == '1 && status == '0 && !run && cnt_en == '0 && cnt_flat == '0));

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> !irq);

    p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0));

    p_halt_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && !bus_wr) |=> $stable(cnt_flat));

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_n
        p_wrap_flags_r7: assert property (@(posedge clk) disable iff (rst)
            ovf[n] |=> status[n]);

        p_none_code_r4: assert property (@(posedge clk) disable iff (rst)
            (sel_regs[CODE_W*n +: CODE_W] == '1 && !bus_wr)
            |=> $stable(cnt_flat[CNT_W*n +: CNT_W]));

        p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
            !bus_wr |=> (CNT_W'(cnt_flat[CNT_W*n +: CNT_W]
                                - $past(cnt_flat[CNT_W*n +: CNT_W])) <= CNT_W'(1)));
    end

endmodule

bind evbank_top evbank_chk #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .CODE_W(CODE_W), .SEL_REGS(SEL_REGS)
) u_chk (
    .clk(clk), .rst(rst), .run(run), .cnt_en(cnt_en), .mask(mask),
    .status(status), .ovf(ovf), .sel_regs(sel_regs), .cnt_flat(cnt_flat),
    .bus_wr(bus_wr), .irq(irq)
);

// File: tb/tb_evbank_top.sv
module tb_evbank_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ev_vld = '0;
    logic [31:0] ev_code = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [7:0]  bus_wstrb = '0;
    logic [63:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    evbank_top dut (
        .clk(clk), .rst(rst), .ev_vld(ev_vld), .ev_code(ev_code),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [3:0]  vld;
        logic [31:0] codes;
        logic [7:0]  hits;
    } vec_t;

    // counter codes: c0 00, c1 01, c2 02, c3 03, c4 20, c5 21, c6 00, c7 FF
    localparam vec_t VECS [8] = '{
        '{4'b0001, 32'h0000_0000, 8'h41},
        '{4'b0011, 32'h0000_0201, 8'h06},
        '{4'b1111, 32'h2120_0303, 8'h38},
        '{4'b0000, 32'h0000_0000, 8'h00},
        '{4'b1111, 32'hFFFF_FFFF, 8'h00},
        '{4'b0100, 32'h0021_0000, 8'h20},
        '{4'b1010, 32'h2001_0021, 8'h51},
        '{4'b1111, 32'h0000_0000, 8'h41}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [63:0] d, input logic [7:0] s);
        bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic fire(input logic [3:0] v, input logic [31:0] c);
        ev_vld = v; ev_code = c;
        @(negedge clk);
        ev_vld = '0;
    endtask

    task automatic chk_reg(input string req, input logic [15:0] a, input logic [63:0] exp);
        logic [63:0] d;
        rd_reg(a, d);
        check(req, d, exp);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int exp_cnt [8];
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_reg("R1 run", 16'h0408, 64'h0);
        chk_reg("R1 enable", 16'h1C00, 64'h0);
        chk_reg("R1 mask", 16'h0800, 64'hFF);
        chk_reg("R1 status", 16'h0808, 64'h0);
        chk_reg("R1 sel0", 16'h1D00, 64'hFFFF_FFFF);
        chk_reg("R1 sel1", 16'h1D04, 64'hFFFF_FFFF);
        chk_reg("R1 cnt0", 16'h1E00, 64'h0);
        chk_reg("R1 cnt7", 16'h1E38, 64'h0);
        check("R1 irq", 64'(irq), 64'h0);

        // R11 unmapped and clear register read zero
        chk_reg("R11 unmapped", 16'h0000, 64'h0);
        chk_reg("R11 clear reads zero", 16'h080C, 64'h0);

        wr_reg(16'h1D00, 64'h0302_0100, 8'h0F);
        wr_reg(16'h1D04, 64'hFF00_2120, 8'h0F);
        wr_reg(16'h1C00, 64'hFF, 8'h0F);
        wr_reg(16'h0408, 64'h2_0000, 8'h0F);
        chk_reg("R3 sel0 readback", 16'h1D00, 64'h0302_0100);
        chk_reg("R3 sel1 readback", 16'h1D04, 64'hFF00_2120);

        // R5/R4 table of event patterns
        for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
        for (int v = 0; v < 8; v++) begin
            fire(VECS[v].vld, VECS[v].codes);
            for (int c = 0; c < 8; c++) begin
                if (VECS[v].hits[c]) exp_cnt[c]++;
                chk_reg($sformatf("R5 vec%0d cnt%0d", v, c), 16'h1E00 + 16'(8*c), 64'(exp_cnt[c]));
            end
        end

        // R6 global stop
        wr_reg(16'h0408, 64'h0, 8'h0F);
        fire(4'b1111, 32'h0302_0100);
        chk_reg("R6 global off cnt0", 16'h1E00, 64'(exp_cnt[0]));
        chk_reg("R6 global off cnt1", 16'h1E08, 64'(exp_cnt[1]));
        wr_reg(16'h0408, 64'h2_0000, 8'h0F);
        chk_reg("R6 run readback", 16'h0408, 64'h2_0000);

        // R6 per-counter enable
        wr_reg(16'h1C00, 64'hFD, 8'h0F);
        fire(4'b0001, 32'h0000_0001);
        chk_reg("R6 counter disabled", 16'h1E08, 64'(exp_cnt[1]));
        wr_reg(16'h1C00, 64'hFF, 8'h0F);

        // R2 counter width, reserved bits, strobes
        wr_reg(16'h1E10, 64'hFFFF_1234_5678_9ABC, 8'hFF);
        chk_reg("R2 full write", 16'h1E10, 64'h0000_1234_5678_9ABC);
        wr_reg(16'h1E10, 64'h0000_0000_0000_00EE, 8'h01);
        chk_reg("R2 byte strobe", 16'h1E10, 64'h0000_1234_5678_9AEE);
        wr_reg(16'h1E10, 64'hFFFF_FFFF_FFFF_FFFF, 8'hC0);
        chk_reg("R2 reserved ignored", 16'h1E10, 64'h0000_1234_5678_9AEE);

        // R3 single field update for counter 6
        wr_reg(16'h1D04, 64'h0042_0000, 8'h04);
        chk_reg("R3 field write", 16'h1D04, 64'hFF42_2120);
        fire(4'b0001, 32'h0000_0042);
        chk_reg("R3 cnt6 new code", 16'h1E30, 64'(exp_cnt[6] + 1));
        chk_reg("R3 cnt0 old code", 16'h1E00, 64'(exp_cnt[0]));

        // R7 wrap sets status
        wr_reg(16'h1E18, 64'h0000_FFFF_FFFF_FFFF, 8'hFF);
        fire(4'b0001, 32'h0000_0003);
        chk_reg("R7 wrap to zero", 16'h1E18, 64'h0);
        chk_reg("R7 status", 16'h0808, 64'h08);
        check("R9 masked irq low", 64'(irq), 64'h0);

        // R9 unmask
        wr_reg(16'h0800, 64'hF7, 8'h0F);
        check("R9 unmasked irq high", 64'(irq), 64'h1);

        // R8 write-one-to-clear
        wr_reg(16'h080C, 64'h00, 8'h0F);
        chk_reg("R8 zero write keeps", 16'h0808, 64'h08);
        check("R8 irq still high", 64'(irq), 64'h1);
        wr_reg(16'h080C, 64'h08, 8'h0F);
        chk_reg("R8 cleared", 16'h0808, 64'h0);
        check("R8 irq low after clear", 64'(irq), 64'h0);

        // R10 write beats same-cycle event
        ev_vld = 4'b0001; ev_code = 32'h0;
        wr_reg(16'h1E00, 64'h5, 8'hFF);
        ev_vld = '0;
        chk_reg("R10 write wins", 16'h1E00, 64'h5);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule